// File: doc/BRIEF.md
# Parallel Bus Panel Frame Writer

This block pushes one frame of pixels into a display panel that keeps its own frame memory, using an 8080-style parallel write bus with an active-low chip select, an active-low write strobe and a data bus. Software programs a timing word that sets four strobe phases in pixel-clock cycles. It then issues a trigger command. The engine pulls pixels one at a time from a valid/ready pixel source and wraps each pixel in a chip-select window with one write pulse. When the last pixel of the programmed frame has left, it raises a pending frame-done flag. The flag drives the interrupt line when its enable is set.

The block is meant to be clocked at twice the rate that the frame geometry and refresh rate would need. A frame then finishes well before the panel's next tearing-effect pulse. A second trigger while a frame is in flight is refused, because restarting a transfer part-way can reset the panel.

Register writes use a single-cycle strobe with a 2-bit address:
- 0 selects the timing word.
- 1 selects the trigger register.
- 2 selects interrupt control.

Top module: `pbus_frame_writer`

## Requirements
- R1: After reset, cs_n and wr_n are 1, busy and irq are 0, and cfg_q reads 0x00100. This means CS setup, WR setup and WR hold are 0 and WR active is 1.
- R2: A write to address 0 stores the 20-bit timing word, and cfg_q reads back exactly the value written. The fields are:
  - CS setup in bits [19:16]
  - WR setup in bits [15:12]
  - WR active in bits [11:8]
  - WR hold in bits [7:4]
  - interface enable in bit 0
- R3: A frame starts only on a write to address 1 that meets all of these conditions:
  - reg_wdata bit 0 (CPU-bus trigger mode) is 1.
  - reg_wdata bit 1 (trigger command) is 1.
  - The interface enable is set.
  - The block is idle.
  - frame_w × frame_h is non-zero.

  busy is 1 from the cycle after that write. frame_w and frame_h are sampled at that write.
- R4: Any trigger write that misses one of the R3 conditions is ignored, and busy stays at its value. This covers a trigger received while a frame is in flight: the frame in progress keeps its pixel count and no new frame follows it.
- R5: While busy, the engine waits for a pixel with cs_n and wr_n both 1 and pix_ready 1. A pixel is taken at a clock edge where pix_valid and pix_ready are both 1, and cs_n goes to 0 at that same edge.
- R6: Every phase lasts its field value plus one cycles. After the pixel is taken, the pixel cycle runs as follows:
  - cs_n is 0 with wr_n 1 for (CS setup + 1) + (WR setup + 1) cycles.
  - wr_n is 0 for WR active + 1 cycles.
  - cs_n stays 0 with wr_n 1 for WR hold + 1 cycles.
  - cs_n returns to 1.

  wr_n is never 0 while cs_n is 1.
- R7: data takes the value of pix_data at the handshake edge and holds it unchanged for the whole time cs_n is 0.
- R8: Exactly frame_w × frame_h write pulses are produced per frame, carrying the pixels in the order the source delivered them.
- R9: At the end of the hold phase of the last pixel, busy falls and the frame-done pending flag is set at the same clock edge, with cs_n at 1.
- R10: irq is the pending flag gated by the interrupt enable. A write to address 2 loads the enable from bit 0 and clears the pending flag if bit 1 is 1. A frame completing in the same cycle as a clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 timing, 1 trigger, 2 interrupt control |
| reg_wdata | input | 20 | Register write data |
| cfg_q | output | 20 | Current timing word |
| frame_w | input | DIM_W | Frame width in pixels, sampled at trigger |
| frame_h | input | DIM_W | Frame height in lines, sampled at trigger |
| pix_valid | input | 1 | Pixel source has a pixel |
| pix_data | input | DW | Pixel value from the source |
| pix_ready | output | 1 | Engine takes a pixel this cycle if pix_valid is 1 |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| data | output | DW | Panel data bus |
| busy | output | 1 | Frame in flight |
| irq | output | 1 | Frame-done interrupt |

## Verification
The checks assume the following about the block's inputs:
- Register writes are single-cycle pulses whose address and data are settled before the sampling edge.
- Address 3 is never written.
- The pixel source may withhold pix_valid for any number of cycles.

The bench drives every input shortly after a rising edge and samples the outputs at the falling edge. It feeds pixels through the valid/ready handshake, both continuously and with valid toggling every other cycle, so stalls land inside the fetch wait without disturbing a pixel cycle that is already under way. Timing fields are taken only from 4-bit values and frame sizes stay within the 6-bit width used by the bench. Because of this, the assertions about strobe nesting, data hold and busy/flag alignment are only ever exposed to legal stimulus.

// File: rtl/pbus_frame_writer.sv
module pbus_frame_writer #(
  parameter int DW    = 16,
  parameter int DIM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [19:0]      reg_wdata,
  output logic [19:0]      cfg_q,
  input  logic [DIM_W-1:0] frame_w,
  input  logic [DIM_W-1:0] frame_h,
  input  logic             pix_valid,
  input  logic [DW-1:0]    pix_data,
  output logic             pix_ready,
  output logic             cs_n,
  output logic             wr_n,
  output logic [DW-1:0]    data,
  output logic             busy,
  output logic             irq
);
  localparam int CNT_W = 2 * DIM_W;
  localparam int PH_W = 4;
  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_TRIG = 2'd1;
  localparam logic [1:0] A_IRQ = 2'd2;
  localparam logic [19:0] CFG_RST = 20'h00100;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CSS, S_WRS, S_ACT, S_HOLD} st_t;

  st_t              st;
  logic [19:0]      cfg;
  logic [PH_W-1:0]  ph;
  logic [CNT_W-1:0] pix_cnt, total_q;
  logic [DW-1:0]    data_q;
  logic             irq_en, irq_pend;

  wire [PH_W-1:0] t_cs   = cfg[19:16];
  wire [PH_W-1:0] t_ws   = cfg[15:12];
  wire [PH_W-1:0] t_act  = cfg[11:8];
  wire [PH_W-1:0] t_hold = cfg[7:4];
  wire            if_en  = cfg[0];

  wire [CNT_W-1:0] total = CNT_W'(frame_w) * CNT_W'(frame_h);
  wire trig_hit = reg_we && reg_addr == A_TRIG && &reg_wdata[1:0] && if_en
                  && st == S_IDLE && total != '0;
  wire ph_end = ph == '0;
  wire last_pix = (pix_cnt + CNT_W'(1)) == total_q;
  wire frame_done = st == S_HOLD && ph_end && last_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= CFG_RST;
    else if (reg_we && reg_addr == A_CFG) cfg <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= '0;
      pix_cnt <= '0;
      total_q <= '0;
      data_q  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (trig_hit) begin
            st      <= S_FETCH;
            pix_cnt <= '0;
            total_q <= total;
          end
        S_FETCH:
          if (pix_valid) begin
            st     <= S_CSS;
            data_q <= pix_data;
            ph     <= t_cs;
          end
        S_CSS:
          if (ph_end) begin st <= S_WRS; ph <= t_ws; end
          else ph <= ph - PH_W'(1);
        S_WRS:
          if (ph_end) begin st <= S_ACT; ph <= t_act; end
          else ph <= ph - PH_W'(1);
        S_ACT:
          if (ph_end) begin st <= S_HOLD; ph <= t_hold; end
          else ph <= ph - PH_W'(1);
        S_HOLD:
          if (ph_end) begin
            st      <= last_pix ? S_IDLE : S_FETCH;
            pix_cnt <= pix_cnt + CNT_W'(1);
          end else ph <= ph - PH_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_IRQ) irq_en <= reg_wdata[0];
      if (frame_done) irq_pend <= 1'b1;
      else if (reg_we && reg_addr == A_IRQ && reg_wdata[1]) irq_pend <= 1'b0;
    end
  end

  assign cfg_q     = cfg;
  assign pix_ready = st == S_FETCH;
  assign cs_n      = st == S_IDLE || st == S_FETCH;
  assign wr_n      = st != S_ACT;
  assign busy      = st != S_IDLE;
  assign data      = data_q;
  assign irq       = irq_pend && irq_en;
endmodule

// File: rtl/pbus_frame_writer_chk.sv
module pbus_frame_writer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_addr,
  input logic [19:0]   reg_wdata,
  input logic          pix_ready,
  input logic          cs_n,
  input logic          wr_n,
  input logic [DW-1:0] data,
  input logic          busy,
  input logic          pend
);
  a_r6_wr_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> $stable(data));

  a_r5_ready_only_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (busy && cs_n && wr_n));

  a_r9_done_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pend && cs_n));

  a_r4_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == 2'd1 && reg_wdata[1:0] == 2'b11));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && wr_n));
endmodule

bind pbus_frame_writer pbus_frame_writer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pix_ready(pix_ready), .cs_n(cs_n), .wr_n(wr_n),
  .data(data), .busy(busy), .pend(irq_pend)
);

// File: tb/sim_pbus_frame_writer.sv
module sim_pbus_frame_writer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DIM_W = 6;
  localparam int NV = 6;
  // {gap, cs, ws, act, hold, w, h}
  localparam logic [27:0] VEC [NV] = '{
    28'h0_0000_32, 28'h0_1231_22, 28'h1_0110_41,
    28'h0_FFFF_12, 28'h1_2053_11, 28'h0_0012_53 };

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [19:0] reg_wdata = 0;
  logic [19:0] cfg_q;
  logic [DIM_W-1:0] frame_w = 0, frame_h = 0;
  logic pix_valid = 0;
  logic [DW-1:0] pix_data = 0;
  logic pix_ready, cs_n, wr_n, busy, irq;
  logic [DW-1:0] data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int e_cs, e_ws, e_wa, e_h;
  logic [DW-1:0] pbase = 0;
  int src_idx = 0; bit hs = 0, src_on = 0, src_gap = 0, tick = 0;
  int cs_run = 0, pre_wr = 0, wr_run = 0, n_pulse = 0;
  int bad_cs = 0, bad_setup = 0, bad_wr = 0, bad_data = 0, bad_stable = 0, bad_sync = 0;
  bit seen_wr = 0, prev_cs = 1, prev_wr = 1, prev_busy = 0, prev_irq = 0;
  logic [DW-1:0] prev_data = 0;

  pbus_frame_writer #(.DW(DW), .DIM_W(DIM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_q(cfg_q), .frame_w(frame_w), .frame_h(frame_h),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .cs_n(cs_n), .wr_n(wr_n), .data(data), .busy(busy), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // pixel source
  always @(negedge clk) begin
    if (hs) src_idx++;
    pix_valid = src_on && !(src_gap && tick);
    tick = !tick;
    pix_data = DW'(pbase + DW'(src_idx));
    hs = pix_valid && pix_ready;
  end

  // bus monitor
  always @(negedge clk) if (rst_n) begin
    if (!cs_n) begin
      cs_run++;
      if (!prev_cs && data !== prev_data) bad_stable++;
    end else if (!prev_cs) begin
      if (cs_run != e_cs + e_ws + e_wa + e_h + 4) bad_cs++;
      cs_run = 0; seen_wr = 0; pre_wr = 0;
    end
    if (!cs_n && wr_n && !seen_wr) pre_wr++;
    if (!wr_n) begin
      if (prev_wr) begin
        seen_wr = 1;
        if (pre_wr != e_cs + e_ws + 2) bad_setup++;
      end
      wr_run++;
    end else if (!prev_wr) begin
      if (wr_run != e_wa + 1) bad_wr++;
      if (data !== DW'(pbase + DW'(n_pulse))) bad_data++;
      n_pulse++; wr_run = 0;
    end
    if (prev_busy && !busy && !cs_n) bad_sync++;
    if (irq && !prev_irq && busy) bad_sync++;
    prev_cs = cs_n; prev_wr = wr_n; prev_busy = busy; prev_irq = irq; prev_data = data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [19:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic clear_stats();
    n_pulse = 0; bad_cs = 0; bad_setup = 0; bad_wr = 0;
    bad_data = 0; bad_stable = 0; bad_sync = 0;
  endtask

  task automatic setup_frame(input int cs, input int ws, input int wa, input int h,
                             input int fw, input int fh, input bit gap, input int fidx);
    e_cs = cs; e_ws = ws; e_wa = wa; e_h = h;
    wreg(2'd0, {cs[3:0], ws[3:0], wa[3:0], h[3:0], 4'b0001});
    frame_w = DIM_W'(fw); frame_h = DIM_W'(fh);
    pbase = DW'(16'h1000 + fidx * 256);
    src_idx = 0; hs = 0; src_gap = gap;
    clear_stats();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic frame_checks(input int total, input string tag);
    chk(n_pulse == total, {"R8 pulse count ", tag}, n_pulse, total);
    chk(bad_wr == 0, {"R6 wr active width ", tag}, bad_wr, 0);
    chk(bad_setup == 0, {"R6 cs-to-wr setup ", tag}, bad_setup, 0);
    chk(bad_cs == 0, {"R6 cs window length ", tag}, bad_cs, 0);
    chk(bad_stable == 0, {"R7 data hold ", tag}, bad_stable, 0);
    chk(bad_data == 0, {"R8 pixel order ", tag}, bad_data, 0);
    chk(bad_sync == 0, {"R9 busy/flag alignment ", tag}, bad_sync, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cs_n === 1'b1 && wr_n === 1'b1, "R1 strobes idle", {cs_n, wr_n}, 3);
    chk(busy === 1'b0 && irq === 1'b0, "R1 busy/irq low", {busy, irq}, 0);
    chk(cfg_q === 20'h00100, "R1 timing reset value", cfg_q, 20'h00100);

    wreg(2'd0, 20'hABCDE);
    chk(cfg_q === 20'hABCDE, "R2 timing readback", cfg_q, 20'hABCDE);

    // R4: interface disabled
    wreg(2'd0, 20'h00100);
    frame_w = 2; frame_h = 2;
    wreg(2'd1, 20'h3);
    repeat (4) @(negedge clk);
    chk(busy === 1'b0, "R4 trigger ignored when interface off", busy, 0);

    // R3: mode bit clear
    wreg(2'd0, 20'h00101);
    wreg(2'd1, 20'h2);
    repeat (4) @(negedge clk);
    chk(busy === 1'b0, "R3 trigger needs mode bit", busy, 0);

    // R4: zero size
    frame_w = 0;
    wreg(2'd1, 20'h3);
    repeat (4) @(negedge clk);
    chk(busy === 1'b0, "R4 zero-size trigger ignored", busy, 0);

    // table of frames
    wreg(2'd2, 20'h3);
    src_on = 1;
    for (int v = 0; v < NV; v++) begin
      logic [27:0] t;
      t = VEC[v];
      setup_frame(t[23:20], t[19:16], t[15:12], t[11:8], t[7:4], t[3:0], t[24], v);
      wreg(2'd1, 20'h3);
      #1;
      chk(busy === 1'b1, "R3 busy after trigger", busy, 1);
      wait_idle();
      chk(irq === 1'b1, "R9 flag set at end of frame", irq, 1);
      frame_checks(int'(t[7:4]) * int'(t[3:0]), $sformatf("vec%0d", v));
      wreg(2'd2, 20'h3);
      #1;
      chk(irq === 1'b0, "R10 write-1 clears pending", irq, 0);
    end

    // R5: source stalled after trigger
    src_on = 0;
    setup_frame(1, 0, 2, 1, 2, 1, 0, 10);
    wreg(2'd1, 20'h3);
    repeat (8) @(negedge clk);
    chk(busy && pix_ready && cs_n && wr_n, "R5 waits for pixel with cs high",
        {busy, pix_ready, cs_n, wr_n}, 15);
    @(posedge clk); #1 src_on = 1;
    wait_idle();
    frame_checks(2, "stall");
    wreg(2'd2, 20'h3);

    // R4: retrigger while busy
    setup_frame(3, 3, 3, 3, 2, 2, 0, 11);
    wreg(2'd1, 20'h3);
    repeat (5) @(posedge clk);
    wreg(2'd1, 20'h3);
    wait_idle();
    repeat (60) @(negedge clk);
    chk(busy === 1'b0, "R4 no restart after retrigger", busy, 0);
    chk(n_pulse == 4, "R4 retrigger keeps pixel count", n_pulse, 4);

    // R10: enable gating
    wreg(2'd2, 20'h2);
    setup_frame(0, 0, 1, 0, 3, 1, 0, 12);
    wreg(2'd1, 20'h3);
    wait_idle();
    chk(irq === 1'b0, "R10 irq masked while disabled", irq, 0);
    wreg(2'd2, 20'h1);
    #1;
    chk(irq === 1'b1, "R10 pending kept, shows when enabled", irq, 1);
    wreg(2'd2, 20'h3);
    #1;
    chk(irq === 1'b0, "R10 cleared", irq, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule